// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral with four 32-bit registers on a plain register bus. The bus has a write strobe, a byte address, write data and combinational read data. Software arms the watchdog, then keeps it alive by writing a restart word at intervals. If software stops doing so, the down-counter runs out. The block then records a timeout and raises an interrupt level, a reset pulse of selectable length, or both.

Every change to the two configuration registers must carry a fixed key in its upper bits, or the write is dropped. A restart takes effect only if the whole written word equals one magic value. The reload value is a 12-bit coarse field that fills the top of the counter, and `FINE_W` zero bits sit below it. A two-bit select picks one of four prescaler divisors, and the counter steps once per prescaler tick.

Top module: `key_watchdog`

## Requirements
- R1: After reset, the mode register reads 0x0, the counter control register reads 0x3FFF (reload 0xFFF, select 3), status reads 0, and both outputs are low.
- R2: A write to offset 0x0 updates the mode register only when bits 23:12 equal 0xABC. The mode fields are bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable and bits 5:4 pulse-length code. On readback the key bits read as zero. A write with any other key leaves the register unchanged.
- R3: A write to offset 0x4 updates counter control only when bits 31:16 equal 0x0092. The fields are bits 13:2 reload and bits 1:0 prescaler select. The key reads back as zero. A write with any other key is ignored.
- R4: A write of exactly 0x00001999 to offset 0x8 reloads the counter to reload × 2^FINE_W, restarts the prescaler and clears the timeout. Any other value written there has no effect. Offset 0x8 reads as zero.
- R5: Select codes 0, 1, 2 and 3 divide by 8, 64, 512 and 4096. The timeout sets exactly reload × 2^FINE_W × divisor clock edges after the edge that loaded the counter.
- R6: On expiry, status bit 0 (offset 0xC) becomes 1 and the counter stops. The bit stays set until a restart or a 0→1 change of the enable bit.
- R7: When the reset-output enable bit is set, each expiry produces one high pulse on `wdog_rst`. The pulse starts on the expiry edge and lasts 2, 4, 8 or 16 cycles for length codes 0, 1, 2 and 3. No pulse is produced when the bit is clear.
- R8: `wdog_irq` is high exactly while the interrupt enable bit and the timeout status are both set. A restart therefore drops it.
- R9: Clearing the enable bit freezes the counter, and no timeout occurs while it is clear. Setting the enable bit from 0 reloads the counter and starts a full period.
- R10: A valid restart that lands on the same edge as the final tick wins: no timeout and no pulse occur, and a full new period begins.
- R11: A reload field of 0 makes the watchdog expire on the first prescaler tick.
- R12: The status register is read-only. Writes to offset 0xC change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data including key bits |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wdog_rst | output | 1 | Timed reset pulse on expiry |
| wdog_irq | output | 1 | Interrupt level while timed out |

## Verification
The sharpest collision is a valid restart arriving on the very edge where the final prescaler tick would expire the counter. Reload and expiry then compete for the same counter and status registers. The bench places the restart write so that its edge lands exactly on the computed expiry edge. It expects status, interrupt and reset pulse all to stay low, and the next expiry to come one full period later. A second overlap is an enable write that also restarts an expired watchdog. This is judged by status clearing and the full period being timed afresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned BUS_W    = 32;
   localparam int unsigned RELOAD_W = 12;

   typedef enum logic [1:0] {
      SLOT_MODE = 2'd0,
      SLOT_CTRL = 2'd1,
      SLOT_KICK = 2'd2,
      SLOT_STAT = 2'd3
   } slot_e;

   localparam logic [11:0]      MODE_KEY  = 12'hABC;
   localparam logic [15:0]      CTRL_KEY  = 16'h0092;
   localparam logic [BUS_W-1:0] KICK_WORD = 32'h0000_1999;

   typedef struct packed {
      logic [1:0] plen;
      logic       irq_en;
      logic       rst_en;
      logic       en;
   } mode_t;

   typedef struct packed {
      logic [RELOAD_W-1:0] reload;
      logic [1:0]          sel;
   } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              tmo,
   output mode_t             mode_q,
   output ctrl_t             ctrl_q,
   output logic              kick_ok,
   output logic              en_rise,
   output logic [BUS_W-1:0]  rdata
);

   slot_e slot;
   logic  in_win;
   logic  hit_mode;
   logic  hit_ctrl;

   assign slot   = slot_e'(addr[3:2]);
   assign in_win = ((addr >> 4) == '0) && (addr[1:0] == 2'b00);

   assign hit_mode = wr && in_win && (slot == SLOT_MODE) && (wdata[23:12] == MODE_KEY);
   assign hit_ctrl = wr && in_win && (slot == SLOT_CTRL) && (wdata[31:16] == CTRL_KEY);
   assign kick_ok  = wr && in_win && (slot == SLOT_KICK) && (wdata == KICK_WORD);
   assign en_rise  = hit_mode && wdata[0] && !mode_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ctrl_q <= '{reload: {RELOAD_W{1'b1}}, sel: 2'd3};
      end else begin
         if (hit_mode) begin
            mode_q <= '{plen: wdata[5:4], irq_en: wdata[2], rst_en: wdata[1], en: wdata[0]};
         end
         if (hit_ctrl) begin
            ctrl_q <= '{reload: wdata[RELOAD_W+1:2], sel: wdata[1:0]};
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (in_win) begin
         unique case (slot)
            SLOT_MODE: rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
            SLOT_CTRL: rdata = {{(BUS_W-RELOAD_W-2){1'b0}}, ctrl_q.reload, ctrl_q.sel};
            SLOT_KICK: rdata = '0;
            SLOT_STAT: rdata = {{(BUS_W-1){1'b0}}, tmo};
         endcase
      end
   end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int unsigned PS_LOG0 = 3,
   parameter int unsigned PS_LOG1 = 6,
   parameter int unsigned PS_LOG2 = 9,
   parameter int unsigned PS_LOG3 = 12,
   parameter int unsigned PRE_W   = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clear,
   input  logic [1:0] sel,
   output logic       tick
);

   function automatic int unsigned log_at(input int unsigned idx);
      case (idx)
         0:       return PS_LOG0;
         1:       return PS_LOG1;
         2:       return PS_LOG2;
         default: return PS_LOG3;
      endcase
   endfunction

   logic [PRE_W-1:0] pcnt;
   logic [3:0]       taps;

   for (genvar i = 0; i < 4; i++) begin : g_tap
      localparam int unsigned L = log_at(i);
      assign taps[i] = &pcnt[L-1:0];
   end

   assign tick = run && taps[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (clear) begin
         pcnt <= '0;
      end else if (run) begin
         pcnt <= pcnt + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned RELOAD_W = 12,
   parameter int unsigned FINE_W   = 12,
   parameter int unsigned CNT_W    = RELOAD_W + FINE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                load,
   input  logic                tick,
   input  logic [RELOAD_W-1:0] reload,
   output logic [CNT_W-1:0]    count_q,
   output logic                tmo_q,
   output logic                running,
   output logic                fire
);

   assign running = en && !tmo_q;
   assign fire    = running && tick && !load && (count_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         tmo_q   <= 1'b0;
      end else if (load) begin
         count_q <= {reload, {FINE_W{1'b0}}};
         tmo_q   <= 1'b0;
      end else if (fire) begin
         count_q <= '0;
         tmo_q   <= 1'b1;
      end else if (running && tick) begin
         count_q <= count_q - 1'b1;
      end
   end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned LEN_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic       arm,
   input  logic [1:0] plen,
   output logic       pulse
);

   logic [LEN_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
      end else if (fire && arm) begin
         left <= LEN_W'(2) << plen;
      end else if (left != '0) begin
         left <= left - 1'b1;
      end
   end

   assign pulse = (left != '0);

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned FINE_W  = 12,
   parameter int unsigned PS_LOG0 = 3,
   parameter int unsigned PS_LOG1 = 6,
   parameter int unsigned PS_LOG2 = 9,
   parameter int unsigned PS_LOG3 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              wdog_rst,
   output logic              wdog_irq
);

   localparam int unsigned CNT_W = RELOAD_W + FINE_W;
   localparam int unsigned PRE_W = PS_LOG3;
   localparam int unsigned LEN_W = 5;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover the four register slots");
   end
   if (FINE_W < 1 || FINE_W > 16) begin : g_bad_fine
      $error("FINE_W out of range 1..16");
   end
   if (PS_LOG0 < 1 || PS_LOG0 > PS_LOG1 || PS_LOG1 > PS_LOG2 || PS_LOG2 > PS_LOG3 || PS_LOG3 > 16) begin : g_bad_ps
      $error("prescaler exponents must rise and stay within 1..16");
   end

   mode_t             mode_q;
   ctrl_t             ctrl_q;
   logic              kick_ok;
   logic              en_rise;
   logic              load;
   logic              tick;
   logic              running;
   logic              fire;
   logic              tmo_q;
   logic [CNT_W-1:0]  count_q;

   assign load = kick_ok || en_rise;

   wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .tmo     (tmo_q),
      .mode_q  (mode_q),
      .ctrl_q  (ctrl_q),
      .kick_ok (kick_ok),
      .en_rise (en_rise),
      .rdata   (bus_rdata)
   );

   wdog_prescale #(
      .PS_LOG0 (PS_LOG0),
      .PS_LOG1 (PS_LOG1),
      .PS_LOG2 (PS_LOG2),
      .PS_LOG3 (PS_LOG3),
      .PRE_W   (PRE_W)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .clear (load),
      .sel   (ctrl_q.sel),
      .tick  (tick)
   );

   wdog_count #(
      .RELOAD_W (RELOAD_W),
      .FINE_W   (FINE_W),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode_q.en),
      .load    (load),
      .tick    (tick),
      .reload  (ctrl_q.reload),
      .count_q (count_q),
      .tmo_q   (tmo_q),
      .running (running),
      .fire    (fire)
   );

   wdog_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .arm   (mode_q.rst_en),
      .plen  (mode_q.plen),
      .pulse (wdog_rst)
   );

   assign wdog_irq = mode_q.irq_en && tmo_q;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kick_ok,
   input logic             load,
   input logic             tick,
   input logic             running,
   input logic             en_q,
   input logic             tmo_q,
   input logic             wdog_rst,
   input logic [CNT_W-1:0] count_q,
   input logic [11:0]      reload
);

   // R6
   tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_q && !load) |=> tmo_q);

   // R4
   kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_ok |=> (!tmo_q && (count_q == (CNT_W'($past(reload)) << (CNT_W - 12)))));

   // R7
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst) |-> $rose(tmo_q));

   // R10
   kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_ok && !wdog_rst) |=> !wdog_rst);

   // R9
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !load) |=> $stable(count_q));

   // R5
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick && !load) |=> $stable(count_q));

endmodule

bind key_watchdog wdog_chk #(.CNT_W(CNT_W)) u_wdog_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .kick_ok  (kick_ok),
   .load     (load),
   .tick     (tick),
   .running  (running),
   .en_q     (mode_q.en),
   .tmo_q    (tmo_q),
   .wdog_rst (wdog_rst),
   .count_q  (count_q),
   .reload   (ctrl_q.reload)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;

   localparam int unsigned FW = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdog_rst;
   logic        wdog_irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   key_watchdog #(.ADDR_W(4), .FINE_W(FW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wdog_rst  (wdog_rst),
      .wdog_irq  (wdog_irq)
   );

   function automatic int unsigned div_of(input int unsigned s);
      return 8 << (3 * s);
   endfunction

   function automatic int unsigned span(input int unsigned rl, input int unsigned s);
      return rl * (1 << FW) * div_of(s);
   endfunction

   function automatic logic [31:0] mode_word(input logic en, input logic re, input logic ie, input logic [1:0] pl);
      return 32'h00AB_C000 | {26'd0, pl, 1'b0, ie, re, en};
   endfunction

   function automatic logic [31:0] ctrl_word(input logic [11:0] rl, input logic [1:0] s);
      return 32'h0092_0000 | {18'd0, rl, s};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_stat(input string tag, input logic exp);
      logic [31:0] v;
      rd(4'hC, v);
      chk(tag, v, {31'd0, exp});
   endtask

   task automatic arm(input logic [11:0] rl, input logic [1:0] s, input logic re, input logic ie, input logic [1:0] pl);
      wr(4'h0, mode_word(1'b0, 1'b0, 1'b0, 2'd0));
      wr(4'h4, ctrl_word(rl, s));
      wr(4'h0, mode_word(1'b1, re, ie, pl));
   endtask

   initial begin
      #(190000 * 8);
      n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int unsigned seed;
      seed = 32'd11;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, v); chk("R1 mode", v, 32'h0);
      rd(4'h4, v); chk("R1 ctrl", v, 32'h3FFF);
      chk_stat("R1 status", 1'b0);
      chk("R1 rst", 32'(wdog_rst), 32'h0);
      chk("R1 irq", 32'(wdog_irq), 32'h0);

      // R2 mode key
      wr(4'h0, mode_word(1'b0, 1'b1, 1'b1, 2'd3));
      rd(4'h0, v); chk("R2 good key", v, 32'h36);
      wr(4'h0, 32'h00AB_D001);
      rd(4'h0, v); chk("R2 bad key", v, 32'h36);
      wr(4'h0, mode_word(1'b0, 1'b0, 1'b0, 2'd0));

      // R3 ctrl key
      wr(4'h4, ctrl_word(12'h005, 2'd1));
      rd(4'h4, v); chk("R3 good key", v, 32'h15);
      wr(4'h4, 32'h0093_0000 | 32'h3FFE);
      rd(4'h4, v); chk("R3 bad key", v, 32'h15);

      // R5 R6 R7 R8 R4 random configurations
      for (int it = 0; it < 8; it++) begin
         logic [11:0] rl;
         logic [1:0]  s, pl;
         logic        re, ie;
         int          t, len;
         rl = 12'($urandom_range(1, 3));
         s  = 2'($urandom_range(0, 2));
         pl = 2'($urandom_range(0, 3));
         re = 1'($urandom_range(0, 1));
         ie = 1'($urandom_range(0, 1));
         if (it == 0) begin re = 1'b1; ie = 1'b1; end
         t = int'(span(rl, s));
         arm(rl, s, re, ie, pl);
         step(t - 1);
         chk_stat("R5 before expiry", 1'b0);
         chk("R7 no early pulse", 32'(wdog_rst), 32'h0);
         step(1);
         chk_stat("R5 at expiry", 1'b1);
         chk("R8 irq level", 32'(wdog_irq), 32'(ie));
         len = 0;
         while (wdog_rst && len < 40) begin
            len++;
            step(1);
         end
         chk("R7 pulse length", 32'(len), re ? (32'd2 << pl) : 32'd0);
         step(30);
         chk_stat("R6 sticky", 1'b1);
         chk("R7 single pulse", 32'(wdog_rst), 32'h0);
         wr(4'h8, 32'h0000_1999);
         chk_stat("R4 restart clears", 1'b0);
         chk("R8 irq cleared", 32'(wdog_irq), 32'h0);
      end

      // R5 largest divisor
      arm(12'd1, 2'd3, 1'b0, 1'b0, 2'd0);
      step(int'(span(1, 3)) - 1);
      chk_stat("R5 div4096 before", 1'b0);
      step(1);
      chk_stat("R5 div4096 at", 1'b1);

      // R4 wrong restart word ignored
      arm(12'd2, 2'd0, 1'b0, 1'b0, 2'd0);
      step(29);
      wr(4'h8, 32'h0000_1998);
      rd(4'h8, v); chk("R4 reads zero", v, 32'h0);
      step(64 - 1 - 30);
      chk_stat("R4 bad word before", 1'b0);
      step(1);
      chk_stat("R4 bad word at", 1'b1);

      // R4 valid restart extends
      arm(12'd2, 2'd0, 1'b0, 1'b0, 2'd0);
      step(39);
      wr(4'h8, 32'h0000_1999);
      step(63);
      chk_stat("R4 extended before", 1'b0);
      step(1);
      chk_stat("R4 extended at", 1'b1);

      // R10 restart on the final tick edge
      arm(12'd2, 2'd0, 1'b1, 1'b1, 2'd1);
      step(63);
      wr(4'h8, 32'h0000_1999);
      chk_stat("R10 no timeout", 1'b0);
      chk("R10 no pulse", 32'(wdog_rst), 32'h0);
      chk("R10 no irq", 32'(wdog_irq), 32'h0);
      step(63);
      chk_stat("R10 next before", 1'b0);
      step(1);
      chk_stat("R10 next at", 1'b1);

      // R9 disable freezes, enable reloads
      arm(12'd2, 2'd0, 1'b1, 1'b0, 2'd0);
      step(20);
      wr(4'h0, mode_word(1'b0, 1'b1, 1'b0, 2'd0));
      step(200);
      chk_stat("R9 frozen", 1'b0);
      chk("R9 no pulse", 32'(wdog_rst), 32'h0);
      wr(4'h0, mode_word(1'b1, 1'b0, 1'b0, 2'd0));
      step(63);
      chk_stat("R9 reload before", 1'b0);
      step(1);
      chk_stat("R9 reload at", 1'b1);

      // R11 zero reload
      arm(12'd0, 2'd0, 1'b0, 1'b0, 2'd0);
      step(7);
      chk_stat("R11 before tick", 1'b0);
      step(1);
      chk_stat("R11 first tick", 1'b1);

      // R12 status not writable
      wr(4'hC, 32'h0000_0000);
      chk_stat("R12 write zero", 1'b1);
      wr(4'hC, 32'h0000_1999);
      chk_stat("R12 write kick word", 1'b1);
      rd(4'h4, v); chk("R12 ctrl untouched", v, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule